// File: doc/BRIEF.md
# 1-Wire Bus Timing Engine

This block owns one open-drain 1-Wire line and produces every edge the bus master needs: the long reset pulse with its presence check, and the fixed-length time slots that carry write and read bits. It takes one command at a time: a bus reset, a write of up to 64 bits, or a read of up to 64 bits. It returns a presence indication, the received bits, a one-cycle completion pulse and a one-cycle error pulse. A sequencer above it builds ROM and function transactions out of these primitives.

The pad is modelled as a pull-low enable (`line_pull`). Driving it high pulls the line low. Releasing it lets the external pull-up raise the line. The line is read back through a two-stage synchronizer. All bit timings are written in microseconds and converted to clock cycles through the `CLK_MHZ` parameter, which gives the number of clock cycles per microsecond. One free-running phase counter times every phase. Fixed compare points on that counter decide when the line is released, when it is sampled and when a phase ends.

Top module: `owt_timing_engine`

## Requirements
- R1: After reset the line is released (`line_pull` = 0) and `busy`, `done`, `error` and `presence` are all 0.
- R2: A reset command (`cmd_op` = 2'b01) pulls the line low for exactly 490 µs (490·CLK_MHZ cycles) and then releases it.
- R3: Presence is sampled 60 µs after the reset release. `presence` becomes 1 if the line reads low at that instant and 0 if it reads high. Each reset command clears the previous value.
- R4: A reset command ends with a `done` pulse exactly 490 µs after the release.
- R5: Every read or write slot starts by pulling the line low. Slots of one command start exactly 64 µs apart, and the line is released no later than 62 µs into each slot.
- R6: In a write slot (`cmd_op` = 2'b10), a data bit of 1 releases the line at 7 µs and a data bit of 0 releases it at 62 µs.
- R7: In a read slot (`cmd_op` = 2'b11), the line is released at 1 µs and sampled at 7 µs. A high line is stored as 1 and a low line as 0.
- R8: Bits go out least-significant first, starting at `wr_data[0]`. Read bits are returned right-aligned in `rd_data[n-1:0]`, with the first bit received in bit 0, and all higher bits are 0.
- R9: `done` is a one-cycle pulse that comes 64 µs after the start of the last slot. `busy` is 1 from the cycle after a started command is accepted until the cycle that shows `done`.
- R10: A read of 0 bits, or a read or write of more than 64 bits, gives a one-cycle `error` pulse in the cycle after acceptance. The line is not touched and `busy` stays 0.
- R11: A command presented while `busy` is 1 is ignored. The running command keeps its slot count and timing, and no further slot follows its `done`.
- R12: A write of 0 bits gives a `done` pulse in the cycle after acceptance, with no slot on the line. `cmd_op` = 2'b00 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ cycles per microsecond |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 00 none, 01 bus reset, 10 write, 11 read |
| cmd_bits | input | 7 | Number of bits to write or read (1 to 64) |
| wr_data | input | 64 | Write bits, bit 0 sent first |
| line_in | input | 1 | Raw level of the bus line (asynchronous) |
| line_pull | output | 1 | 1 = pull the line low, 0 = release |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command completion |
| error | output | 1 | One-cycle pulse for a rejected command |
| presence | output | 1 | A device answered the last bus reset |
| rd_data | output | 64 | Bits from the last read, right-aligned |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any command, and that `line_in` may change at any time, since it is only looked at through the synchronizer. The bench keeps the modelled device's line changes well inside the windows the block samples. A read-0 device holds the line low for 20 µs, and a present device answers from 20 µs to 150 µs after release. This means a sample two cycles late from the synchronizer still sees a settled level. Commands are only strobed for one cycle at a time. The overlap case from R11 is the single deliberate exception, where a strobe is issued while `busy` is high.

// File: rtl/owt_pkg.sv
// Shared encodings for the 1-Wire timing engine.
// Assumes: the command encoding below is also used by the sequencer above.
package owt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_RST_LOW  = 2'b01,
        ST_RST_WAIT = 2'b10,
        ST_SLOT     = 2'b11
    } owt_state_e;

endpackage

// File: rtl/owt_sync.sv
// Multi-stage synchronizer for the asynchronous bus line level.
// Assumes: the line idles high, so every stage resets to 1.
module owt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    // Shift the raw level through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/owt_phase_counter.sv
// Free-running phase counter. The clear input restarts it at zero for the next cycle.
// Assumes: the owner clears it at least every 2**W cycles.
module owt_phase_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Count cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/owt_shift_reg.sv
// Right-shifting data register shared by write (bit 0 leaves) and read (bit enters at top).
// Assumes: load and shift are never requested in the same cycle.
module owt_shift_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    // Load a new word or move one bit towards bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {shift_in, q[W-1:1]};
    end
endmodule

// File: rtl/owt_timing_engine.sv
// 1-Wire bus timing engine: reset/presence sequence and read/write time slots.
// All phases are timed by one phase counter against fixed compare points
// derived from CLK_MHZ (clock cycles per microsecond).
// Assumes: line_in is the raw pad level; line_pull drives an open-drain low.
module owt_timing_engine
    import owt_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int MAX_BITS = 64,
    parameter int CW       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [CW-1:0]       cmd_bits,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic                line_in,
    output logic                line_pull,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic                presence,
    output logic [MAX_BITS-1:0] rd_data
);
    localparam int RST_CYC  = 490 * CLK_MHZ;
    localparam int PRES_CYC = 60 * CLK_MHZ;
    localparam int SLOT_CYC = 64 * CLK_MHZ;
    localparam int W1_CYC   = 7 * CLK_MHZ;
    localparam int W0_CYC   = 62 * CLK_MHZ;
    localparam int RREL_CYC = 1 * CLK_MHZ;
    localparam int SAMP_CYC = 7 * CLK_MHZ;
    localparam int TW       = $clog2(RST_CYC + 1);

    localparam logic [TW-1:0] T_RST_END  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] T_PRES     = TW'(PRES_CYC - 1);
    localparam logic [TW-1:0] T_SLOT_END = TW'(SLOT_CYC - 1);
    localparam logic [TW-1:0] T_W1_REL   = TW'(W1_CYC - 1);
    localparam logic [TW-1:0] T_W0_REL   = TW'(W0_CYC - 1);
    localparam logic [TW-1:0] T_RD_REL   = TW'(RREL_CYC - 1);
    localparam logic [TW-1:0] T_SAMPLE   = TW'(SAMP_CYC - 1);
    localparam logic [CW-1:0] MAX_CNT    = CW'(MAX_BITS);

    owt_state_e          state_q;
    owt_op_e             op_q;
    logic [CW-1:0]       nbits_q;
    logic [CW-1:0]       bit_idx_q;
    logic                pull_q, busy_q, done_q, err_q, pres_q;
    logic [MAX_BITS-1:0] rd_q;

    logic                line_s;
    logic [TW-1:0]       cnt;
    logic                cnt_clr;
    logic [MAX_BITS-1:0] sh_q;
    logic                sh_load, sh_shift, sh_in;
    logic                accept, phase_end, last_bit;
    logic [TW-1:0]       rel_pt;
    logic [CW-1:0]       align_amt;

    owt_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_s)
    );

    owt_phase_counter #(.W(TW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .cnt  (cnt)
    );

    owt_shift_reg #(.W(MAX_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(cmd_op == OP_WRITE ? wr_data : '0),
        .shift   (sh_shift),
        .shift_in(sh_in),
        .q       (sh_q)
    );

    // Decode command acceptance, phase ends and the release point of the slot.
    always_comb begin
        accept    = (state_q == ST_IDLE) && cmd_valid && (cmd_op != OP_NONE);
        phase_end = ((state_q == ST_RST_LOW || state_q == ST_RST_WAIT) && cnt == T_RST_END) ||
                    ((state_q == ST_SLOT) && cnt == T_SLOT_END);
        last_bit  = (bit_idx_q == nbits_q - 1'b1);
        if (op_q == OP_READ) rel_pt = T_RD_REL;
        else if (sh_q[0])    rel_pt = T_W1_REL;
        else                 rel_pt = T_W0_REL;
        cnt_clr   = (state_q == ST_IDLE) || phase_end;
        sh_load   = accept;
        sh_shift  = (state_q == ST_SLOT) &&
                    (((op_q == OP_WRITE) && cnt == T_SLOT_END) ||
                     ((op_q == OP_READ)  && cnt == T_SAMPLE));
        sh_in     = (op_q == OP_READ) ? line_s : 1'b0;
        align_amt = MAX_CNT - nbits_q;
    end

    // Sequence the reset and slot phases and drive the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            nbits_q   <= '0;
            bit_idx_q <= '0;
            pull_q    <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            pres_q    <= 1'b0;
            rd_q      <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= owt_op_e'(cmd_op);
                        nbits_q   <= cmd_bits;
                        bit_idx_q <= '0;
                        if (cmd_op == OP_RESET) begin
                            state_q <= ST_RST_LOW;
                            pull_q  <= 1'b1;
                            busy_q  <= 1'b1;
                            pres_q  <= 1'b0;
                        end else if (cmd_bits > MAX_CNT ||
                                     (cmd_op == OP_READ && cmd_bits == '0)) begin
                            err_q <= 1'b1;
                        end else if (cmd_bits == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_SLOT;
                            pull_q  <= 1'b1;
                            busy_q  <= 1'b1;
                        end
                    end
                end
                ST_RST_LOW: begin
                    if (phase_end) begin
                        pull_q  <= 1'b0;
                        state_q <= ST_RST_WAIT;
                    end
                end
                ST_RST_WAIT: begin
                    if (cnt == T_PRES) pres_q <= ~line_s;
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (cnt == rel_pt) pull_q <= 1'b0;
                    if (phase_end) begin
                        if (last_bit) begin
                            state_q <= ST_IDLE;
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            if (op_q == OP_READ) rd_q <= sh_q >> align_amt;
                        end else begin
                            bit_idx_q <= bit_idx_q + 1'b1;
                            pull_q    <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign line_pull = pull_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign error     = err_q;
    assign presence  = pres_q;
    assign rd_data   = rd_q;
endmodule

// File: rtl/owt_checker.sv
// Protocol checker for the 1-Wire timing engine, bound to every instance.
// Assumes: rst_n is low for at least one edge before the first command.
module owt_checker #(
    parameter int CLK_MHZ = 50
) (
    input logic clk,
    input logic rst_n,
    input logic line_pull,
    input logic busy,
    input logic done,
    input logic error,
    input logic presence
);
    localparam int RST_CYC = 490 * CLK_MHZ;

    logic [31:0] pull_run;

    // Length of the current low pulse on the line.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_pull) pull_run <= '0;
        else                      pull_run <= pull_run + 1;
    end

    // R2: no low pulse is ever longer than the reset pulse.
    a_r2_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= RST_CYC);

    // R9: the line is only pulled while a command runs.
    a_r9_pull_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> busy);

    // R9: busy only ends together with done.
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done lasts exactly one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a command never both completes and fails.
    a_r10_done_xor_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R10: a rejected command never shows busy.
    a_r10_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !busy);

    // R3: presence only changes while a command is running.
    a_r3_presence_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(presence));
endmodule

bind owt_timing_engine owt_checker #(.CLK_MHZ(CLK_MHZ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_pull(line_pull),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .presence (presence)
);

// File: tb/owt_timing_engine_tb.sv
// Self-checking bench: device model on the line, pulse-width recorder,
// a vector table of write/read commands, then directed corner cases.
module owt_timing_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ  = 2;
    localparam int RSTC = 490 * MHZ;
    localparam int SLOT = 64 * MHZ;
    localparam int W1   = 7 * MHZ;
    localparam int W0   = 62 * MHZ;
    localparam int RREL = 1 * MHZ;

    // Vector: {op[1:0], bits[6:0], data[63:0]}; for reads data is the device pattern.
    localparam int NV = 6;
    localparam logic [72:0] VEC [NV] = '{
        {2'b10, 7'd8,  64'h0000_0000_0000_00A5},
        {2'b10, 7'd1,  64'h0000_0000_0000_0001},
        {2'b10, 7'd3,  64'h0000_0000_0000_0006},
        {2'b11, 7'd8,  64'h0000_0000_0000_003C},
        {2'b11, 7'd1,  64'h0000_0000_0000_0000},
        {2'b11, 7'd64, 64'h8D3C_0F5A_1234_C6E1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [6:0]  cmd_bits = '0;
    logic [63:0] wr_data = '0;
    logic        line_in;
    logic        line_pull, busy, done, error, presence;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // device model and recorder state
    logic        dev_low = 1'b0;
    logic        dev_present = 1'b0;
    logic        dev_reading = 1'b0;
    logic [63:0] dev_pat = '0;
    int          dev_i = 0;
    int          wait_cnt = 0;
    int          low_cnt = 0;
    logic        prev_pull = 1'b0;
    int          run = 0;
    int          nw = 0;
    int          nr = 0;
    int          widths [64];
    int          rises  [64];
    int          fall_cyc = 0;
    int          end_cyc = 0;
    logic        got_done, got_err;

    owt_timing_engine #(.CLK_MHZ(MHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bits(cmd_bits), .wr_data(wr_data), .line_in(line_in),
        .line_pull(line_pull), .busy(busy), .done(done), .error(error),
        .presence(presence), .rd_data(rd_data)
    );

    assign line_in = !(line_pull || dev_low);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record pulse widths and slot starts; model the device answers.
    always @(negedge clk) begin
        if (wait_cnt > 0)     wait_cnt = wait_cnt - 1;
        else if (low_cnt > 0) low_cnt = low_cnt - 1;
        if (line_pull && !prev_pull) begin
            if (nr < 64) rises[nr] = cyc;
            nr = nr + 1;
            run = 1;
            if (dev_reading) begin
                if (!dev_pat[dev_i % 64]) begin
                    wait_cnt = 0;
                    low_cnt  = 20 * MHZ;
                end
                dev_i = dev_i + 1;
            end
        end else if (line_pull) begin
            run = run + 1;
        end else if (prev_pull) begin
            if (nw < 64) widths[nw] = run;
            nw = nw + 1;
            fall_cyc = cyc;
            if (dev_present && !dev_reading && run >= RSTC) begin
                wait_cnt = 20 * MHZ;
                low_cnt  = 130 * MHZ;
            end
        end
        prev_pull = line_pull;
        dev_low = (wait_cnt == 0) && (low_cnt > 0);
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Issue one command and wait for done or error.
    task automatic run_cmd(input logic [1:0] op, input logic [6:0] n, input logic [63:0] d);
        @(negedge clk);
        nw = 0; nr = 0; dev_i = 0;
        dev_pat = d;
        dev_reading = (op == 2'b11);
        cmd_op = op; cmd_bits = n; wr_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_done = 1'b0; got_err = 1'b0;
        for (int t = 0; t < 20000 && !got_done && !got_err; t++) begin
            if (done)  begin got_done = 1'b1; end_cyc = cyc; end
            if (error) got_err = 1'b1;
            if (!got_done && !got_err) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!line_pull && !busy && !done && !error && !presence, "R1 reset state",
            {line_pull, busy, done, error, presence}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!line_pull && !busy, "R1 idle after reset", {line_pull, busy}, 0);

        // Table of write and read commands.
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [6:0]  n;
            logic [63:0] d;
            logic [63:0] msk;
            int          bad;
            {op, n, d} = VEC[v];
            run_cmd(op, n, d);
            chk(got_done && !got_err, "R9 command completes", got_done, 1);
            chk(nw == n && nr == n, "R5 one slot per bit", nw, n);
            bad = 0;
            for (int i = 0; i < n; i++) begin
                int exp_w;
                if (op == 2'b11) exp_w = RREL;         // R7 release at 1 us
                else exp_w = d[i] ? W1 : W0;           // R6 and R8 LSB first
                if (widths[i] != exp_w) bad++;
                if (widths[i] > W0) bad++;             // R5 released by 62 us
                if (i > 0 && rises[i] - rises[i-1] != SLOT) bad++;
            end
            chk(bad == 0, op == 2'b11 ? "R7 read slot shape" : "R6 write slot shape", bad, 0);
            chk(end_cyc - rises[n-1] == SLOT, "R9 done after last slot",
                end_cyc - rises[n-1], SLOT);
            if (op == 2'b11) begin
                msk = (n == 64) ? '1 : ((64'd1 << n) - 1);
                chk(rd_data == (d & msk), "R8 read data aligned", rd_data, d & msk);
            end
        end

        // R2 R3 R4: reset with a device present.
        dev_present = 1'b1;
        run_cmd(2'b01, 7'd0, '0);
        chk(got_done, "R4 reset completes", got_done, 1);
        chk(nw == 1 && widths[0] == RSTC, "R2 reset pulse width", widths[0], RSTC);
        chk(end_cyc - fall_cyc == RSTC, "R4 done after release", end_cyc - fall_cyc, RSTC);
        chk(presence == 1'b1, "R3 presence detected", presence, 1);

        // R3: reset with no device clears presence.
        dev_present = 1'b0;
        run_cmd(2'b01, 7'd0, '0);
        chk(presence == 1'b0, "R3 no presence", presence, 0);

        // R10: rejected counts.
        run_cmd(2'b11, 7'd0, '0);
        chk(got_err && nr == 0 && !busy, "R10 read zero rejected", {got_err, busy}, 2);
        run_cmd(2'b11, 7'd65, '0);
        chk(got_err && nr == 0, "R10 read 65 rejected", got_err, 1);
        run_cmd(2'b10, 7'd100, '1);
        chk(got_err && nr == 0, "R10 write 100 rejected", got_err, 1);

        // R12: write of zero bits, and opcode none.
        run_cmd(2'b10, 7'd0, '0);
        chk(got_done && nr == 0, "R12 zero write done", {got_done, nr[0]}, 2);
        @(negedge clk);
        cmd_op = 2'b00; cmd_bits = 7'd8; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !line_pull && !done, "R12 no-op ignored", {busy, line_pull, done}, 0);

        // R11: reset strobe while a 4-bit write runs.
        @(negedge clk);
        nw = 0; nr = 0; dev_reading = 1'b0;
        cmd_op = 2'b10; cmd_bits = 7'd4; wr_data = 64'h5; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'b01; cmd_bits = 7'd0;
        repeat (50) @(negedge clk);
        cmd_valid = 1'b0;
        for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(nr == 4 && nw == 4, "R11 busy command unchanged", nr, 4);
        chk(widths[0] == W1 && widths[1] == W0 && widths[2] == W1 && widths[3] == W0,
            "R11 slot pattern kept", widths[1], W0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule